// File: doc/BRIEF.md
# Hook Command to Serial Register Writer

This block lets a line-interface device that is set up over a serial register port be driven by a host that only has a single static hook-control wire. It synchronises and debounces that wire. On every settled change of its level, in either direction, it sends a full load of the device's registers over a three-wire serial port. The register contents come from a bank of configuration switches. The hook bit in register 0 is derived from the wire's level, read through a polarity switch.

A momentary write button gives manual control. A settled press sends a single write to register 0, and in that write the polarity switch no longer selects a polarity: its value is the hook state itself. Triggers that arrive while a sequence is running are remembered and served afterwards, with an automatic load ahead of a manual write.

Top module: `hook_ser_xlat`

## Requirements
- R1: After reset, `cs_n` is high, `sclk` is low, `sdo` is low and `busy` is low.
- R2: Both `hook_cmd` and `wr_btn` pass through a two-flop synchronizer. A level change counts only after it has held for DEB_CYCLES consecutive clocks, so shorter pulses produce no frame. The settled hook level starts at 0 after reset.
- R3: Every settled transition of `hook_cmd`, rising or falling, starts a load of NUM_REGS frames. The frames go to addresses 1, 2, …, NUM_REGS-1, and address 0 comes last.
- R4: In an automatic load, the data byte for register k is `cfg_sw[8k+7:8k]`. The one exception is bit HOOK_BIT of register 0, which is 1 (off-hook) when the settled hook level equals `offhook_pol` and 0 (on-hook) otherwise.
- R5: A settled press (low to high) of `wr_btn` sends exactly one frame, to address 0. Its data is `cfg_sw[7:0]` with bit HOOK_BIT replaced by `offhook_pol`. Releasing the button sends nothing.
- R6: Each frame has 16 bits, sent MSB first: the 8-bit address, then the 8-bit data. `cs_n` stays low for exactly 32*CLK_DIV clocks. `sclk` idles low and gives 16 pulses, each high and low for CLK_DIV clocks. `sdo` changes only as `sclk` falls, or when `cs_n` falls.
- R7: After each frame, `cs_n` stays high for CLK_DIV clocks. `busy` rises in the same clock as the first `cs_n` assertion of a sequence and stays high until the gap after the last frame ends. A full load therefore keeps `busy` high for NUM_REGS*33*CLK_DIV clocks, and a manual write for 33*CLK_DIV clocks.
- R8: A trigger that arrives while a sequence runs is held pending and served after that sequence ends. When an automatic and a manual trigger are both pending, the automatic load goes first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hook_cmd | input | 1 | Static host hook command, asynchronous |
| offhook_pol | input | 1 | Polarity switch in automatic mode; hook value in manual mode |
| wr_btn | input | 1 | Momentary manual write button, active high, asynchronous |
| cfg_sw | input | NUM_REGS*8 | Configuration switch bits, one byte per register |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| sdo | output | 1 | Serial data toward the device |
| busy | output | 1 | High while a write sequence runs |

## Verification
A settled hook transition and a settled button press can reach the sequencer in the same clock, and either one can also land while a load is already being sent. The bench produces the first case by changing both inputs on the same edge while the block is idle. It produces the second by pressing the button and flipping the hook wire in the middle of a load. Each case passes only if the decoded frame stream shows the full automatic load or loads first, with register 0 last, followed by the single manual frame with the correct hook bits.

// File: rtl/hook_ser_xlat.sv
module hook_ser_xlat #(
  parameter int CLK_DIV    = 2,
  parameter int DEB_CYCLES = 8,
  parameter int NUM_REGS   = 4,
  parameter int HOOK_BIT   = 0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  hook_cmd,
  input  logic                  offhook_pol,
  input  logic                  wr_btn,
  input  logic [NUM_REGS*8-1:0] cfg_sw,
  output logic                  sclk,
  output logic                  cs_n,
  output logic                  sdo,
  output logic                  busy
);

  localparam int DCW = $clog2(DEB_CYCLES + 1);
  localparam int CDW = $clog2(CLK_DIV + 1);
  localparam int RW  = $clog2(NUM_REGS + 1);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_GAP} st_t;

  logic [1:0]     hk_s, bt_s;
  logic [1:0]     lvl, chg;
  logic [DCW-1:0] dcnt [2];
  logic           pend_a, pend_m;
  st_t            st;
  logic [CDW-1:0] ccnt;
  logic [4:0]     ph;
  logic [RW-1:0]  fidx;
  logic           man, hook_q;
  logic [15:0]    shreg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hk_s <= '0;
      bt_s <= '0;
    end else begin
      hk_s <= {hk_s[0], hook_cmd};
      bt_s <= {bt_s[0], wr_btn};
    end

  wire [1:0] raw = {bt_s[1], hk_s[1]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lvl <= '0;
      chg <= '0;
      for (int g = 0; g < 2; g++) dcnt[g] <= '0;
    end else begin
      for (int g = 0; g < 2; g++) begin
        chg[g] <= 1'b0;
        if (raw[g] == lvl[g]) dcnt[g] <= '0;
        else if (dcnt[g] == DCW'(DEB_CYCLES - 1)) begin
          lvl[g]  <= raw[g];
          dcnt[g] <= '0;
          chg[g]  <= 1'b1;
        end else dcnt[g] <= dcnt[g] + 1'b1;
      end
    end

  wire hook_evt = chg[0];
  wire btn_evt  = chg[1] & lvl[1];
  wire start    = (st == S_IDLE) && (pend_a || pend_m);
  wire tick     = (ccnt == CDW'(CLK_DIV - 1));
  wire [RW-1:0] last_idx = man ? '0 : RW'(NUM_REGS - 1);

  logic [RW-1:0] ld_idx;
  logic          ld_man, ld_hk;
  logic [7:0]    ld_addr, ld_data;

  always_comb begin
    ld_idx = (st == S_IDLE) ? '0 : fidx + 1'b1;
    ld_man = (st == S_IDLE) ? !pend_a : man;
    ld_hk  = (st == S_IDLE) ? (pend_a ? (lvl[0] ~^ offhook_pol) : offhook_pol) : hook_q;
    ld_addr = (ld_man || ld_idx == RW'(NUM_REGS - 1)) ? 8'd0 : 8'(ld_idx) + 8'd1;
    ld_data = '0;
    for (int k = 0; k < NUM_REGS; k++)
      if (ld_addr == 8'(k)) ld_data = cfg_sw[k*8 +: 8];
    if (ld_addr == 8'd0) ld_data[HOOK_BIT] = ld_hk;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend_a <= 1'b0;
      pend_m <= 1'b0;
    end else begin
      if (hook_evt) pend_a <= 1'b1;
      else if (start && pend_a) pend_a <= 1'b0;
      if (btn_evt) pend_m <= 1'b1;
      else if (start && !pend_a) pend_m <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st     <= S_IDLE;
      ccnt   <= '0;
      ph     <= '0;
      fidx   <= '0;
      man    <= 1'b0;
      hook_q <= 1'b0;
      shreg  <= '0;
    end else begin
      case (st)
        S_IDLE:
          if (start) begin
            st     <= S_SHIFT;
            shreg  <= {ld_addr, ld_data};
            fidx   <= '0;
            man    <= ld_man;
            hook_q <= ld_hk;
            ph     <= '0;
            ccnt   <= '0;
          end
        S_SHIFT: begin
          ccnt <= tick ? '0 : ccnt + 1'b1;
          if (tick) begin
            if (ph == 5'd31) st <= S_GAP;
            else begin
              ph <= ph + 1'b1;
              if (ph[0]) shreg <= {shreg[14:0], 1'b0};
            end
          end
        end
        S_GAP: begin
          ccnt <= tick ? '0 : ccnt + 1'b1;
          if (tick) begin
            if (fidx == last_idx) st <= S_IDLE;
            else begin
              st    <= S_SHIFT;
              fidx  <= ld_idx;
              shreg <= {ld_addr, ld_data};
              ph    <= '0;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end

  assign sclk = (st == S_SHIFT) & ph[0];
  assign cs_n = (st != S_SHIFT);
  assign sdo  = shreg[15];
  assign busy = (st != S_IDLE);

  p_deb_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    chg[0] |-> (lvl[0] == $past(hk_s[1])))
    else $error("p_deb_level_r2");

  p_sdo_hold_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(sdo))
    else $error("p_sdo_hold_high_r6");

  p_busy_with_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !cs_n)
    else $error("p_busy_with_cs_r7");

  p_start_from_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(pend_a || pend_m))
    else $error("p_start_from_pend_r8");

  p_auto_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && pend_a && pend_m) |=> (!man && pend_m))
    else $error("p_auto_first_r8");

  p_manual_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && man) |-> (fidx == '0))
    else $error("p_manual_single_r5");

endmodule

// File: tb/sim_hook_ser_xlat.sv
module sim_hook_ser_xlat;
  localparam int CLK_DIV = 2, DEB = 8, NR = 4, HB = 0;
  localparam int FLEN = 32 * CLK_DIV;
  localparam int BAUTO = NR * 33 * CLK_DIV;
  localparam int BMAN = 33 * CLK_DIV;

  logic clk = 0, rst_n = 0;
  logic hook_cmd = 0, pol = 0, wr_btn = 0;
  logic [NR*8-1:0] cfg = '0;
  logic sclk, cs_n, sdo, busy;

  always #10 clk = ~clk;

  hook_ser_xlat #(.CLK_DIV(CLK_DIV), .DEB_CYCLES(DEB), .NUM_REGS(NR), .HOOK_BIT(HB)) u0 (
    .clk(clk), .rst_n(rst_n), .hook_cmd(hook_cmd), .offhook_pol(pol), .wr_btn(wr_btn),
    .cfg_sw(cfg), .sclk(sclk), .cs_n(cs_n), .sdo(sdo), .busy(busy));

  int tests = 0, fails = 0;
  bit done = 0;

  logic [15:0] fr [256];
  int fbits [256];
  int flen [256];
  int nfr = 0;
  logic [15:0] sh = 0;
  int bits = 0, cslen = 0, bl = 0, last_bl = 0, sdo_bad = 0;
  logic p_sclk = 0, p_cs = 1, p_sdo = 0, p_busy = 0;

  always @(negedge clk) if (rst_n) begin
    if (sclk && !p_sclk) begin sh = {sh[14:0], sdo}; bits++; end
    if (!cs_n) cslen++;
    if (!cs_n && !p_cs && sdo != p_sdo && !(p_sclk && !sclk)) sdo_bad++;
    if (cs_n && !p_cs) begin
      if (nfr < 256) begin fr[nfr] = sh; fbits[nfr] = bits; flen[nfr] = cslen; end
      nfr++; bits = 0; cslen = 0;
    end
    if (busy) bl++;
    else if (p_busy) begin last_bl = bl; bl = 0; end
    p_sclk = sclk; p_cs = cs_n; p_sdo = sdo; p_busy = busy;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(input int addr, input logic hb);
    logic [7:0] d;
    d = cfg[addr*8 +: 8];
    if (addr == 0) d[HB] = hb;
    return {8'(addr), d};
  endfunction

  task automatic settle();
    int q = 0;
    while (q < 60) begin
      @(negedge clk);
      if (busy || !cs_n) q = 0; else q++;
    end
  endtask

  task automatic chk_auto(input int base, input logic lvl, input string req);
    for (int i = 0; i < NR; i++) begin
      int a = (i == NR - 1) ? 0 : i + 1;
      chk({req, " auto frame R3/R4"}, fr[base + i], exp_word(a, lvl == pol));
      chk({req, " bits R6"}, fbits[base + i], 16);
      chk({req, " cs len R6"}, flen[base + i], FLEN);
    end
  endtask

  task automatic chk_man(input int base, input string req);
    chk({req, " manual frame R5"}, fr[base], exp_word(0, pol));
    chk({req, " bits R6"}, fbits[base], 16);
  endtask

  task automatic toggle_hook();
    @(negedge clk); hook_cmd = ~hook_cmd;
  endtask

  task automatic press();
    @(negedge clk); wr_btn = 1;
    repeat (DEB + 20) @(negedge clk);
    wr_btn = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R7 act=%0d exp=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n0;
    logic lv;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R1 cs_n", cs_n, 1); chk("R1 sclk", sclk, 0);
    chk("R1 sdo", sdo, 0); chk("R1 busy", busy, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);

    cfg = 32'hA5C3_3C5A; pol = 1;
    n0 = nfr; toggle_hook(); settle();
    chk("R3 count rise", nfr - n0, NR); chk_auto(n0, 1, "rise");
    chk("R7 busy len auto", last_bl, BAUTO);

    n0 = nfr; toggle_hook(); settle();
    chk("R3 count fall", nfr - n0, NR); chk_auto(n0, 0, "fall");

    pol = 0;
    n0 = nfr; press(); settle();
    chk("R5 count", nfr - n0, 1); chk_man(n0, "press pol0");
    chk("R7 busy len man", last_bl, BMAN);

    n0 = nfr;
    @(negedge clk); hook_cmd = 1; repeat (4) @(negedge clk); hook_cmd = 0;
    @(negedge clk); wr_btn = 1; repeat (4) @(negedge clk); wr_btn = 0;
    settle();
    chk("R2 glitch no frame", nfr - n0, 0);
    chk("R2 glitch busy", busy, 0);

    cfg = 32'h0F1E_2D3C; pol = 1;
    n0 = nfr;
    @(negedge clk); hook_cmd = 1; wr_btn = 1;
    repeat (DEB + 20) @(negedge clk); wr_btn = 0;
    settle();
    chk("R8 same-cycle count", nfr - n0, NR + 1);
    chk_auto(n0, 1, "R8 same-cycle");
    chk_man(n0 + NR, "R8 same-cycle");

    cfg = 32'h1122_3344; pol = 0;
    n0 = nfr; toggle_hook();
    repeat (60) @(negedge clk);
    chk("R7 busy mid", busy, 1);
    press(); toggle_hook();
    settle();
    chk("R8 pending count", nfr - n0, 2 * NR + 1);
    chk_auto(n0, 0, "R8 first");
    chk_auto(n0 + NR, 1, "R8 second");
    chk_man(n0 + 2 * NR, "R8 last");

    for (int it = 0; it < 12; it++) begin
      cfg = {$urandom, $urandom} ;
      pol = 1'($urandom % 2);
      n0 = nfr;
      if ($urandom % 3 == 0) begin
        press(); settle();
        chk("R5 rand count", nfr - n0, 1); chk_man(n0, "rand");
      end else begin
        toggle_hook(); lv = hook_cmd; settle();
        chk("R3 rand count", nfr - n0, NR); chk_auto(n0, lv, "rand");
      end
    end

    chk("R6 sdo edges", sdo_bad, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule